// File: doc/BRIEF.md
# Instruction Length Decoder

This unit sits in an instruction front end. Each cycle it may be handed a 16-byte fetch window and the byte offset where an instruction begins. It walks the chain of optional fields that make up one variable-length instruction. It reports the total length and the offset of every field boundary, or it reports why no length can be given. The result is registered and appears one cycle after the request.

The encoding has several parts, in this order:
- up to four legacy prefixes;
- at most one family prefix;
- the opcode byte;
- an optional operand-mode byte;
- an optional scale/index/base byte;
- a displacement;
- an immediate.

The size of each later field depends on earlier bytes: the prefixes, the family prefix and the operand-mode byte. A small opcode-class table stands in for a full opcode map. Three faults are kept apart: an unlisted opcode, an encoding longer than 15 bytes, and an instruction that runs past the end of the window.

Top module: `insn_len_dec`

## Requirements
- R1: While reset is held, `res_vld`, `res_ok` and all three fault flags are 0.
- R2: Every cycle with `in_vld` high yields exactly one result with `res_vld` high on the following cycle; `res_vld` is low otherwise.
- R3: Legacy prefixes are the bytes F0, F2, F3, 2E, 36, 3E, 26, 64, 65, 66 and 67. At most four are consumed. A fifth prefix byte is taken as the opcode, and since it is unlisted it gives `flt_bad`.
- R4: A family prefix may come only directly after the legacy prefixes. It takes one of three forms:
  - 40–4F, one byte; its bit 3 is the wide flag;
  - C5, two bytes;
  - C4, three bytes.
- R5: The opcode classes are:
  - operand byte only: 00–03, 88–8B;
  - operand byte with a 1-byte immediate: 6B, 80, 83, C6;
  - operand byte with an operand-sized immediate: 69, 81, C7;
  - 1-byte immediate only: 04, EB, B0–B7;
  - operand-sized immediate only: 05, E8, E9;
  - wide immediate: B8–BF;
  - direct address: A0–A3;
  - no further fields: 90, C3.

  Any other opcode gives `flt_bad`.
- R6: In the operand byte, mode is bits 7:6 and the r/m field is bits 2:0. A scale/index/base byte follows when mode is not 11 and r/m is 100.
- R7: Let A be 4, or 2 when a 67 prefix is present. The displacement is:
  - 1 byte for mode 01;
  - A bytes for mode 10;
  - A bytes for mode 00 with r/m 101;
  - A bytes for mode 00 when the scale/index/base byte has base bits 2:0 equal to 101;
  - none otherwise.

  Direct-address opcodes carry an 8-byte displacement, or 4 bytes with a 67 prefix.
- R8: The immediate is sized as follows:
  - 1-byte class: 1 byte;
  - operand-sized class: 4 bytes, or 2 with a 66 prefix;
  - wide class: 8 bytes when the 40–4F prefix has bit 3 set, otherwise sized as the operand-sized class.
- R9: On success, `res_opc_off`, `res_mr_off`, `res_sib_off`, `res_disp_off` and `res_imm_off` give each field's start relative to `in_start`. An absent field has the same offset as the next field. `res_len` is the total length.
- R10: When the total length would exceed 15, `flt_long` is raised.
- R11: `flt_short` is raised in two cases:
  - a prefix, opcode, operand or scale/index/base byte that must be examined lies at window byte 16 or beyond;
  - the instruction ends past byte 16.

  An instruction ending exactly at byte 16 is valid.
- R12: Faults are ranked from highest to lowest:
  1. missing examined byte;
  2. unlisted opcode;
  3. overflow past 15 bytes;
  4. end past the window.

  An over-long encoding that also runs past the window reports only `flt_long`.
- R13: Each result raises exactly one of `res_ok`, `flt_long`, `flt_short` and `flt_bad`. On a fault, the length and all offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| in_win | input | 128 | Fetch window, byte i at bits 8i+7:8i |
| in_start | input | 4 | Offset of the first instruction byte |
| res_vld | output | 1 | Result present |
| res_ok | output | 1 | Length found |
| res_len | output | 4 | Instruction length |
| res_opc_off | output | 4 | Opcode offset |
| res_mr_off | output | 4 | Operand-byte offset |
| res_sib_off | output | 4 | Scale/index/base offset |
| res_disp_off | output | 4 | Displacement offset |
| res_imm_off | output | 4 | Immediate offset |
| flt_long | output | 1 | Longer than 15 bytes |
| flt_short | output | 1 | Runs past the window |
| flt_bad | output | 1 | Unlisted opcode |

## Verification
The overflow check and the end-of-window check can both fire for the same instruction. A 16-byte encoding placed at offset 5 both exceeds 15 bytes and ends past byte 16, and only `flt_long` may appear. A 15-byte encoding is placed at offsets 0, 1 and 2 to pin the window edge: valid, valid, then `flt_short`. Randomly built legal encodings, some placed so they cross the window end, are compared field by field against a model that assembles each instruction from its parts.

// File: rtl/insn_len_dec.sv
module insn_len_dec #(
  parameter int WIN     = 16,
  parameter int MAX_LEN = 15,
  parameter int MAX_PFX = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  input  logic [8*WIN-1:0]             in_win,
  input  logic [$clog2(WIN)-1:0]       in_start,
  output logic                         res_vld,
  output logic                         res_ok,
  output logic [$clog2(MAX_LEN+1)-1:0] res_len,
  output logic [$clog2(MAX_LEN+1)-1:0] res_opc_off,
  output logic [$clog2(MAX_LEN+1)-1:0] res_mr_off,
  output logic [$clog2(MAX_LEN+1)-1:0] res_sib_off,
  output logic [$clog2(MAX_LEN+1)-1:0] res_disp_off,
  output logic [$clog2(MAX_LEN+1)-1:0] res_imm_off,
  output logic                         flt_long,
  output logic                         flt_short,
  output logic                         flt_bad
);
  localparam int PW = $clog2(WIN);
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int RW = LW + 2;
  localparam int AW = PW + RW;

  logic [7:0] wb [WIN];
  for (genvar g = 0; g < WIN; g++) begin : g_byte
    assign wb[g] = in_win[8*g +: 8];
  end

  function automatic logic [7:0] rd(input logic [AW-1:0] a);
    return (a < AW'(WIN)) ? wb[a[PW-1:0]] : 8'h00;
  endfunction

  function automatic logic is_pfx(input logic [7:0] b);
    return b inside {8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                     8'h26, 8'h64, 8'h65, 8'h66, 8'h67};
  endfunction

  // {direct address, imm kind[1:0], operand byte, listed}
  function automatic logic [4:0] op_class(input logic [7:0] b);
    casez (b)
      8'h00, 8'h01, 8'h02, 8'h03,
      8'b1000_10??:                 return 5'b0_00_11;
      8'h6B, 8'h80, 8'h83, 8'hC6:   return 5'b0_01_11;
      8'h69, 8'h81, 8'hC7:          return 5'b0_10_11;
      8'h04, 8'hEB, 8'b1011_0???:   return 5'b0_01_01;
      8'h05, 8'hE8, 8'hE9:          return 5'b0_10_01;
      8'b1011_1???:                 return 5'b0_11_01;
      8'b1010_00??:                 return 5'b1_00_01;
      8'h90, 8'hC3:                 return 5'b0_00_01;
      default:                      return 5'b0_00_00;
    endcase
  endfunction

  logic [AW-1:0] s;
  logic [RW-1:0] npfx, fam_len, opc_rel, mr_rel, sib_rel, disp_rel, imm_rel, len_c, dsz, isz, asize;
  logic [7:0]    fb, mb;
  logic [4:0]    cls;
  logic          osz, asz, rexw, run, inc_s, has_mr, has_sib, bad_c, long_c, short_c, ok_c;

  always_comb begin
    s     = AW'(in_start);
    npfx  = '0;
    osz   = 1'b0;
    asz   = 1'b0;
    run   = 1'b1;
    inc_s = 1'b0;
    for (int k = 0; k < MAX_PFX; k++) begin
      if (run) begin
        if (s + AW'(k) >= AW'(WIN)) begin
          inc_s = 1'b1;
          run   = 1'b0;
        end else if (is_pfx(rd(s + AW'(k)))) begin
          npfx = npfx + 1'b1;
          if (rd(s + AW'(k)) == 8'h66) osz = 1'b1;
          if (rd(s + AW'(k)) == 8'h67) asz = 1'b1;
        end else begin
          run = 1'b0;
        end
      end
    end

    fb      = rd(s + AW'(npfx));
    rexw    = ((fb & 8'hF0) == 8'h40) && ((fb & 8'h08) != 8'h00);
    fam_len = ((fb & 8'hF0) == 8'h40) ? RW'(1) :
              (fb == 8'hC5)           ? RW'(2) :
              (fb == 8'hC4)           ? RW'(3) : RW'(0);

    opc_rel = npfx + fam_len;
    if (s + AW'(opc_rel) >= AW'(WIN)) inc_s = 1'b1;
    cls     = op_class(rd(s + AW'(opc_rel)));
    has_mr  = cls[1];

    mr_rel  = opc_rel + 1'b1;
    mb      = rd(s + AW'(mr_rel));
    if (has_mr && (s + AW'(mr_rel) >= AW'(WIN))) inc_s = 1'b1;
    has_sib = has_mr && ((mb & 8'hC0) != 8'hC0) && ((mb & 8'h07) == 8'h04);

    sib_rel = mr_rel + RW'(has_mr);
    if (has_sib && (s + AW'(sib_rel) >= AW'(WIN))) inc_s = 1'b1;

    asize = asz ? RW'(2) : RW'(4);
    if (cls[4])                    dsz = asz ? RW'(4) : RW'(8);
    else if (!has_mr)              dsz = '0;
    else if ((mb & 8'hC0) == 8'h40) dsz = RW'(1);
    else if ((mb & 8'hC0) == 8'h80) dsz = asize;
    else if ((mb & 8'hC0) == 8'h00 &&
             ((mb & 8'h07) == 8'h05 ||
              (has_sib && (rd(s + AW'(sib_rel)) & 8'h07) == 8'h05)))
                                   dsz = asize;
    else                           dsz = '0;

    case (cls[3:2])
      2'd1:    isz = RW'(1);
      2'd2:    isz = osz ? RW'(2) : RW'(4);
      2'd3:    isz = rexw ? RW'(8) : (osz ? RW'(2) : RW'(4));
      default: isz = '0;
    endcase

    disp_rel = sib_rel + RW'(has_sib);
    imm_rel  = disp_rel + dsz;
    len_c    = imm_rel + isz;

    bad_c   = !inc_s && !cls[0];
    long_c  = !inc_s && cls[0] && (len_c > RW'(MAX_LEN));
    short_c = inc_s || (cls[0] && !long_c && (s + AW'(len_c) > AW'(WIN)));
    ok_c    = !inc_s && !bad_c && !long_c && !short_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld      <= 1'b0;
      res_ok       <= 1'b0;
      flt_long     <= 1'b0;
      flt_short    <= 1'b0;
      flt_bad      <= 1'b0;
      res_len      <= '0;
      res_opc_off  <= '0;
      res_mr_off   <= '0;
      res_sib_off  <= '0;
      res_disp_off <= '0;
      res_imm_off  <= '0;
    end else begin
      res_vld      <= in_vld;
      res_ok       <= in_vld && ok_c;
      flt_long     <= in_vld && long_c;
      flt_short    <= in_vld && short_c;
      flt_bad      <= in_vld && bad_c;
      res_len      <= (in_vld && ok_c) ? len_c[LW-1:0]    : '0;
      res_opc_off  <= (in_vld && ok_c) ? opc_rel[LW-1:0]  : '0;
      res_mr_off   <= (in_vld && ok_c) ? mr_rel[LW-1:0]   : '0;
      res_sib_off  <= (in_vld && ok_c) ? sib_rel[LW-1:0]  : '0;
      res_disp_off <= (in_vld && ok_c) ? disp_rel[LW-1:0] : '0;
      res_imm_off  <= (in_vld && ok_c) ? imm_rel[LW-1:0]  : '0;
    end
  end

  // R2
  req_to_res_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> res_vld);
  // R2
  no_req_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !res_vld);
  // R13
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $countones({res_ok, flt_long, flt_short, flt_bad}) == 1);
  // R11
  fits_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |-> (int'($past(in_start)) + int'(res_len) <= WIN));
  // R9
  field_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ok |-> (res_opc_off < res_mr_off) && (res_mr_off <= res_sib_off) &&
               (res_sib_off <= res_disp_off) && (res_disp_off <= res_imm_off) &&
               (res_imm_off <= res_len) && (res_opc_off < res_len));
  // R13
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_ok) |-> (res_len == '0) && (res_imm_off == '0));
endmodule

// File: tb/insn_len_dec_tb.sv
module insn_len_dec_tb;
  localparam int WIN = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_vld = 1'b0;
  logic [8*WIN-1:0] in_win = '0;
  logic [3:0]       in_start = '0;
  logic             res_vld, res_ok, flt_long, flt_short, flt_bad;
  logic [3:0]       res_len, res_opc_off, res_mr_off, res_sib_off, res_disp_off, res_imm_off;

  always #5 clk = ~clk;

  insn_len_dec u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_win(in_win), .in_start(in_start),
    .res_vld(res_vld), .res_ok(res_ok), .res_len(res_len),
    .res_opc_off(res_opc_off), .res_mr_off(res_mr_off), .res_sib_off(res_sib_off),
    .res_disp_off(res_disp_off), .res_imm_off(res_imm_off),
    .flt_long(flt_long), .flt_short(flt_short), .flt_bad(flt_bad)
  );

  typedef struct {
    int len, opc, mr, sib, dsp, imm;
    bit known, has_mr, has_sib;
  } ins_t;

  typedef struct {
    bit ok, lng, sht, bad;
    int len, opc, mr, sib, dsp, imm;
    string tag;
  } exp_t;

  exp_t         sb_q[$];
  byte unsigned ib[$];
  byte unsigned pq[$];
  int checks = 0, errors = 0, pushed = 0, popped = 0;

  byte unsigned pfx_lst [11] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65, 8'h66, 8'h67};
  byte unsigned op_lst  [24] = '{8'h00, 8'h03, 8'h88, 8'h8B, 8'h6B, 8'h80, 8'h83, 8'hC6, 8'h69, 8'h81,
                                 8'hC7, 8'h04, 8'hEB, 8'hB2, 8'h05, 8'hE8, 8'hE9, 8'hB8, 8'hBD, 8'hA0,
                                 8'hA3, 8'h90, 8'hC3, 8'h89};

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic void cls_of(input byte unsigned op, output bit kn, output bit m,
                                 output int ik, output bit mo);
    kn = 1; m = 0; ik = 0; mo = 0;
    if (op inside {8'h00, 8'h01, 8'h02, 8'h03, [8'h88:8'h8B]}) m = 1;
    else if (op inside {8'h6B, 8'h80, 8'h83, 8'hC6}) begin m = 1; ik = 1; end
    else if (op inside {8'h69, 8'h81, 8'hC7}) begin m = 1; ik = 2; end
    else if (op inside {8'h04, 8'hEB, [8'hB0:8'hB7]}) ik = 1;
    else if (op inside {8'h05, 8'hE8, 8'hE9}) ik = 2;
    else if (op inside {[8'hB8:8'hBF]}) ik = 3;
    else if (op inside {[8'hA0:8'hA3]}) mo = 1;
    else if (op inside {8'h90, 8'hC3}) kn = 1;
    else kn = 0;
  endfunction

  task automatic pset(input int n, input byte unsigned b0, input byte unsigned b1,
                      input byte unsigned b2, input byte unsigned b3);
    pq.delete();
    if (n > 0) pq.push_back(b0);
    if (n > 1) pq.push_back(b1);
    if (n > 2) pq.push_back(b2);
    if (n > 3) pq.push_back(b3);
  endtask

  task automatic build(input int fam, input byte unsigned rex, input byte unsigned op,
                       input byte unsigned mrb, input byte unsigned sbb, output ins_t d);
    bit osz = 0, asz = 0, w = 0, mo;
    int ik, dsz, isz, asize;
    ib.delete();
    foreach (pq[i]) begin
      ib.push_back(pq[i]);
      if (pq[i] == 8'h66) osz = 1;
      if (pq[i] == 8'h67) asz = 1;
    end
    if (fam == 1) begin ib.push_back(rex); w = rex[3]; end
    else if (fam == 2) begin ib.push_back(8'hC5); ib.push_back(8'($urandom)); end
    else if (fam == 3) begin ib.push_back(8'hC4); ib.push_back(8'($urandom)); ib.push_back(8'($urandom)); end
    d.opc = ib.size();
    ib.push_back(op);
    cls_of(op, d.known, d.has_mr, ik, mo);
    d.mr = d.opc + 1;
    if (d.has_mr) ib.push_back(mrb);
    d.has_sib = d.has_mr && (mrb[7:6] != 2'b11) && (mrb[2:0] == 3'b100);
    d.sib = d.mr + int'(d.has_mr);
    if (d.has_sib) ib.push_back(sbb);
    d.dsp = d.sib + int'(d.has_sib);
    asize = asz ? 2 : 4;
    if (mo) dsz = asz ? 4 : 8;
    else if (!d.has_mr) dsz = 0;
    else if (mrb[7:6] == 2'b01) dsz = 1;
    else if (mrb[7:6] == 2'b10) dsz = asize;
    else if (mrb[7:6] == 2'b00 && (mrb[2:0] == 3'b101 || (d.has_sib && sbb[2:0] == 3'b101))) dsz = asize;
    else dsz = 0;
    case (ik)
      1: isz = 1;
      2: isz = osz ? 2 : 4;
      3: isz = w ? 8 : (osz ? 2 : 4);
      default: isz = 0;
    endcase
    for (int i = 0; i < dsz + isz; i++) ib.push_back(8'($urandom));
    d.imm = d.dsp + dsz;
    d.len = d.imm + isz;
  endtask

  task automatic fire(input ins_t d, input int start, input string tag);
    exp_t e;
    logic [8*WIN-1:0] w;
    bit st;
    for (int i = 0; i < WIN; i++) w[8*i +: 8] = 8'($urandom);
    foreach (ib[i]) if (start + i < WIN) w[8*(start+i) +: 8] = ib[i];
    st = (start + d.opc >= WIN) || (d.has_mr && start + d.mr >= WIN) ||
         (d.has_sib && start + d.sib >= WIN);
    e.ok = 0; e.lng = 0; e.sht = 0; e.bad = 0;
    e.len = 0; e.opc = 0; e.mr = 0; e.sib = 0; e.dsp = 0; e.imm = 0;
    e.tag = tag;
    if (st) e.sht = 1;
    else if (!d.known) e.bad = 1;
    else if (d.len > 15) e.lng = 1;
    else if (start + d.len > WIN) e.sht = 1;
    else begin
      e.ok = 1; e.len = d.len; e.opc = d.opc; e.mr = d.mr;
      e.sib = d.sib; e.dsp = d.dsp; e.imm = d.imm;
    end
    in_win = w;
    in_start = 4'(start);
    in_vld = 1'b1;
    sb_q.push_back(e);
    pushed++;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic check_res(input exp_t e);
    checks++;
    if (res_ok !== e.ok || flt_long !== e.lng || flt_short !== e.sht || flt_bad !== e.bad ||
        int'(res_len) != e.len || int'(res_opc_off) != e.opc || int'(res_mr_off) != e.mr ||
        int'(res_sib_off) != e.sib || int'(res_disp_off) != e.dsp || int'(res_imm_off) != e.imm) begin
      errors++;
      $display("FAIL %s (R9 fields): actual ok%0d L%0d S%0d B%0d len%0d off %0d/%0d/%0d/%0d/%0d expected ok%0d L%0d S%0d B%0d len%0d off %0d/%0d/%0d/%0d/%0d",
               e.tag, res_ok, flt_long, flt_short, flt_bad, res_len, res_opc_off, res_mr_off,
               res_sib_off, res_disp_off, res_imm_off, e.ok, e.lng, e.sht, e.bad, e.len,
               e.opc, e.mr, e.sib, e.dsp, e.imm);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected result, expected none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        popped++;
        check_res(e);
      end
    end
  end

  task automatic rand_ins(output ins_t d);
    int np, fam;
    np = $urandom_range(0, 4);
    pq.delete();
    for (int i = 0; i < np; i++) pq.push_back(pfx_lst[$urandom_range(0, 10)]);
    fam = $urandom_range(0, 3);
    build(fam, 8'h40 | 8'($urandom_range(0, 15)), op_lst[$urandom_range(0, 23)],
          8'($urandom), 8'($urandom), d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

  initial begin
    ins_t d;
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_ok !== 1'b0 || flt_long !== 1'b0 || flt_short !== 1'b0 || flt_bad !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual vld%0d ok%0d %0d%0d%0d expected all 0", res_vld, res_ok, flt_long, flt_short, flt_bad);
    end
    rst_n = 1'b1;
    @(negedge clk);

    pset(0, 0, 0, 0, 0); build(1, 8'h48, 8'hB8, 0, 0, d); fire(d, 0, "R8 wide imm with REX bit3");
    pset(1, 8'h66, 0, 0, 0); build(0, 0, 8'hBA, 0, 0, d); fire(d, 3, "R8 wide imm under 66");
    pset(1, 8'h66, 0, 0, 0); build(0, 0, 8'hC7, 8'hC0, 0, d); fire(d, 1, "R8 operand-sized imm under 66");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'hA1, 0, 0, d); fire(d, 0, "R7 direct address 8 bytes");
    pset(1, 8'h67, 0, 0, 0); build(0, 0, 8'hA2, 0, 0, d); fire(d, 2, "R7 direct address under 67");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h8B, 8'h04, 8'h25, d); fire(d, 0, "R7 SIB base 101 disp");
    pset(1, 8'h67, 0, 0, 0); build(0, 0, 8'h8B, 8'h04, 8'h25, d); fire(d, 4, "R7 SIB base 101 disp under 67");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h89, 8'h05, 0, d); fire(d, 0, "R7 mode 00 rm 101");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h8B, 8'hC4, 0, d); fire(d, 7, "R6 register mode rm 100 no SIB");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h80, 8'h44, 8'h11, d); fire(d, 0, "R6 SIB with 1-byte disp");
    pset(4, 8'hF0, 8'h2E, 8'h66, 8'h67); build(0, 0, 8'h66, 0, 0, d); fire(d, 0, "R3 fifth prefix is unlisted");
    pset(4, 8'hF3, 8'h64, 8'h26, 8'h67); build(0, 0, 8'h90, 0, 0, d); fire(d, 0, "R3 four prefixes");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h0F, 0, 0, d); fire(d, 5, "R5 unlisted opcode");
    pset(0, 0, 0, 0, 0); build(1, 8'h48, 8'h66, 0, 0, d); fire(d, 0, "R4 legacy after family prefix");
    pset(0, 0, 0, 0, 0); build(3, 0, 8'h90, 0, 0, d); fire(d, 0, "R4 three-byte family prefix");
    pset(1, 8'hF2, 0, 0, 0); build(2, 0, 8'h8B, 8'h04, 8'h25, d); fire(d, 0, "R4 two-byte family prefix");
    pset(3, 8'hF0, 8'h2E, 8'h3E, 0); build(1, 8'h48, 8'hC7, 8'h84, 8'h00, d);
    fire(d, 0, "R10 exactly 15 bytes");
    fire(d, 1, "R11 15 bytes ending at window edge");
    fire(d, 2, "R11 15 bytes past window edge");
    pset(4, 8'hF0, 8'h2E, 8'h3E, 8'h26); build(1, 8'h48, 8'hC7, 8'h84, 8'h00, d);
    fire(d, 0, "R10 R13 16 bytes");
    fire(d, 5, "R12 overflow and window end together");
    pset(2, 8'hF0, 8'hF0, 0, 0); build(0, 0, 8'h90, 0, 0, d); fire(d, 14, "R11 opcode beyond window");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h8B, 8'h00, 0, d); fire(d, 15, "R11 operand byte beyond window");
    pset(0, 0, 0, 0, 0); build(0, 0, 8'h0F, 0, 0, d); fire(d, 15, "R12 R13 unlisted last byte");

    for (int it = 0; it < 500; it++) begin
      int st;
      rand_ins(d);
      while (d.len > 15) rand_ins(d);
      if ((it % 5) == 4 && d.len >= 2) st = $urandom_range(15, 17 - d.len);
      else st = $urandom_range(16 - d.len, 0);
      fire(d, st, "R5 R6 R7 R8 random");
    end

    in_vld = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (pushed != popped || sb_q.size() != 0 || res_vld !== 1'b0) begin
      errors++;
      $display("FAIL R2: actual %0d results, expected %0d", popped, pushed);
    end
    summary();
    $finish;
  end
endmodule